// File: doc/BRIEF.md
# Cascadable LCD Backplane Sequencer

This block steps a multiplexed segment LCD driver through its backplane phases (up to four) and keeps several identical drivers in step over one shared, wired-AND synchronization line. Each `phase_tick` moves the active backplane to the next phase. The multiplex mode sets how many phases make up one frame: static, 1:2, 1:3 or 1:4.

When a driver enters the last phase of its frame, it pulls the shared line low for one phase period. At all other times it only listens to the line. A falling edge on the line from another driver, seen while this driver is not in its own last phase, forces the local phase to that last index. The next tick then wraps every driver to phase 0 together. After reset all drivers start at phase 0, so a cascade begins aligned. Outputs are digital phase indicators only.

Top module: `lcd_bp_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, `bp_index` is 0, `bp_active` is 4'b0001 and `sync_pull` is 0.
- R2: `bp_index` changes only on the clock edge that samples `phase_tick` high, or on a realignment. Between those edges it holds its value.
- R3: The last phase index equals the `mux_mode` code: 0 = static (1 phase), 1 = 1:2, 2 = 1:3, 3 = 1:4. A tick taken in the last phase wraps the index to 0. Any other tick adds one.
- R4: `sync_pull` (1 = pull the line low) is set on the tick edge that moves the index into the last phase, and is cleared on the next tick edge. In static mode every tick enters the last phase, so `sync_pull` stays high.
- R5: `sync_in` is active low (1 = released). A 1 then 0 on `sync_in`, sampled on edges n-1 and n, is synchronized by two flops. It acts on edge n+2: `bp_index` becomes the last phase index and `sync_pull` clears. The next tick then wraps the index to 0.
- R6: `bp_active` is one-hot, with bit `bp_index` set.
- R7: A falling edge on `sync_in` is ignored while the index is the last phase index or while `sync_pull` is high. This includes the driver's own assertion.
- R8: After `mux_mode` changes, the next tick edge sets `bp_index` to 0 in place of the normal step. This also applies to a tick on the same edge that first sees the new mode.
- R9: When a realignment (R5) and a tick fall on the same edge, the realignment wins and the tick is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | One-cycle pulse that advances the backplane phase |
| mux_mode | input | 2 | Multiplex mode code (0 static, 1 = 1:2, 2 = 1:3, 3 = 1:4) |
| sync_in | input | 1 | Sampled level of the shared sync line, 1 = released |
| bp_index | output | 2 | Index of the active backplane |
| bp_active | output | 4 | One-hot active-backplane strobe |
| sync_pull | output | 1 | Open-drain enable: 1 pulls the sync line low |

## Verification
Every output is registered, so a tick or mode change shows up on the outputs one edge after it is sampled. A falling line edge needs three edges: two synchronizer flops plus the counter load. The bench drives inputs at the falling clock edge and runs a behavioural model that keeps its own queue of line samples. It compares all three outputs at the next falling edge, after both the design and the model have taken the same rising edge. External pulses are placed at twelve offsets against a six-cycle tick. This covers realignment between ticks, a realignment landing on a tick, and pulses that arrive during the driver's own assertion.

// File: rtl/lcd_bp_pkg.sv
package lcd_bp_pkg;

  // Last phase index for a multiplex mode code: code n gives n+1 phases.
  function automatic int unsigned last_phase(input int unsigned mode_code);
    return mode_code;
  endfunction

  // Phase after a normal tick: wrap at or beyond the last index.
  function automatic int unsigned next_phase(input int unsigned cur,
                                             input int unsigned last);
    if (cur >= last) return 0;
    return cur + 1;
  endfunction

  // Number of phases in one frame for a mode code.
  function automatic int unsigned frame_len(input int unsigned mode_code);
    return last_phase(mode_code) + 1;
  endfunction

endpackage

// File: rtl/bp_sync_rx.sv
module bp_sync_rx #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_fall
);
  logic [STAGES-1:0] meta_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= {meta_q[STAGES-2:0], line_in};
      prev_q <= meta_q[STAGES-1];
    end
  end

  assign line_fall = prev_q & ~meta_q[STAGES-1];
endmodule

// File: rtl/bp_mode_track.sv
module bp_mode_track #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              flush_taken,
  output logic              mode_chg,
  output logic              mode_pend,
  output logic              flush_req
);
  logic [MODE_W-1:0] mode_q;
  logic              primed_q;

  assign mode_chg  = primed_q && (mode_in != mode_q);
  assign flush_req = mode_chg | mode_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      primed_q  <= 1'b0;
      mode_pend <= 1'b0;
    end else begin
      mode_q   <= mode_in;
      primed_q <= 1'b1;
      if (flush_taken) mode_pend <= 1'b0;
      else             mode_pend <= mode_pend | mode_chg;
    end
  end
endmodule

// File: rtl/bp_phase_ctr.sv
module bp_phase_ctr #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ext_sync,
  input  logic             flush_req,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] phase_q,
  output logic             pull_q
);
  logic [IDX_W-1:0] step_idx;
  logic [IDX_W-1:0] adv_idx;

  assign step_idx = IDX_W'(lcd_bp_pkg::next_phase(int'(phase_q), int'(last_idx)));
  assign adv_idx  = flush_req ? '0 : step_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pull_q  <= 1'b0;
    end else if (ext_sync) begin
      phase_q <= last_idx;
      pull_q  <= 1'b0;
    end else if (tick) begin
      phase_q <= adv_idx;
      pull_q  <= (adv_idx == last_idx);
    end
  end
endmodule

// File: rtl/bp_strobe_dec.sv
module bp_strobe_dec #(
  parameter int NUM_BP = 4,
  parameter int IDX_W  = 2
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [NUM_BP-1:0] strobe
);
  for (genvar g = 0; g < NUM_BP; g++) begin : g_dec
    assign strobe[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/lcd_bp_sequencer.sv
module lcd_bp_sequencer #(
  parameter int NUM_BP      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_BP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_tick,
  input  logic [IDX_W-1:0]  mux_mode,
  input  logic              sync_in,
  output logic [IDX_W-1:0]  bp_index,
  output logic [NUM_BP-1:0] bp_active,
  output logic              sync_pull
);
  logic             line_fall;
  logic             ext_sync;
  logic             mode_chg;
  logic             mode_pend;
  logic             flush_req;
  logic             flush_taken;
  logic [IDX_W-1:0] last_idx;

  assign last_idx    = IDX_W'(lcd_bp_pkg::last_phase(int'(mux_mode)));
  assign ext_sync    = line_fall && (bp_index != last_idx) && !sync_pull;
  assign flush_taken = phase_tick && !ext_sync;

  bp_sync_rx #(.STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .line_in(sync_in), .line_fall(line_fall)
  );

  bp_mode_track #(.MODE_W(IDX_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .mode_in(mux_mode), .flush_taken(flush_taken),
    .mode_chg(mode_chg), .mode_pend(mode_pend), .flush_req(flush_req)
  );

  bp_phase_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(phase_tick), .ext_sync(ext_sync),
    .flush_req(flush_req), .last_idx(last_idx),
    .phase_q(bp_index), .pull_q(sync_pull)
  );

  bp_strobe_dec #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_dec (
    .idx(bp_index), .strobe(bp_active)
  );
endmodule

// File: rtl/lcd_bp_seq_checker.sv
module lcd_bp_seq_checker #(
  parameter int NUM_BP = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phase_tick,
  input logic [IDX_W-1:0]  mux_mode,
  input logic [IDX_W-1:0]  bp_index,
  input logic [NUM_BP-1:0] bp_active,
  input logic              sync_pull,
  input logic              ext_sync,
  input logic              mode_chg,
  input logic              mode_pend
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_tick && !ext_sync) |=> $stable(bp_index));

  assert_pull_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pull && !mode_chg && !mode_pend) |-> (bp_index == mux_mode));

  assert_pull_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_pull) |-> $past(phase_tick));

  assert_realign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync |=> ((bp_index == $past(mux_mode)) && !sync_pull));

  assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot(bp_active) && bp_active[bp_index]));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tick && !ext_sync && (mode_chg || mode_pend)) |=> (bp_index == '0));
endmodule

bind lcd_bp_sequencer lcd_bp_seq_checker #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .mux_mode(mux_mode),
  .bp_index(bp_index), .bp_active(bp_active), .sync_pull(sync_pull),
  .ext_sync(ext_sync), .mode_chg(mode_chg), .mode_pend(mode_pend)
);

// File: tb/lcd_bp_sequencer_tb.sv
`timescale 1ns/1ps
module lcd_bp_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_tick = 1'b0;
  logic [1:0] mux_mode = 2'd3;
  logic       ext_low = 1'b0;
  logic       sync_in;
  logic [1:0] bp_index;
  logic [3:0] bp_active;
  logic       sync_pull;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;
  int ext_cnt = 0;

  always #2.5 clk = ~clk;

  // Wired-AND line: low if this driver or an external one pulls.
  assign sync_in = !(sync_pull || ext_low);

  lcd_bp_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .mux_mode(mux_mode),
    .sync_in(sync_in), .bp_index(bp_index), .bp_active(bp_active),
    .sync_pull(sync_pull)
  );

  // Behavioural reference model.
  int    m_idx = 0;
  int    m_pull = 0;
  int    m_prev_mode = 0;
  bit    m_primed = 0;
  bit    m_pend = 0;
  int    line_hist[$] = '{1, 1, 1};
  string idx_tag = "R1";
  string pull_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_pull = 0; m_primed = 0; m_pend = 0;
      line_hist = '{1, 1, 1};
      idx_tag = "R1"; pull_tag = "R1";
    end else begin
      int  last;
      bit  fell, changed, realign;
      last    = int'(mux_mode);
      // line_hist[0] is the newest sample, [2] the oldest.
      fell    = (line_hist[2] == 1) && (line_hist[1] == 0);
      changed = m_primed && (int'(mux_mode) != m_prev_mode);
      realign = fell && (m_idx != last) && (m_pull == 0);
      idx_tag = "R2"; pull_tag = "R4";
      if (realign) begin
        m_idx = last; m_pull = 0;
        m_pend = m_pend | changed;
        idx_tag = phase_tick ? "R9" : "R5"; pull_tag = "R5";
      end else if (phase_tick) begin
        if (changed || m_pend) begin
          m_idx = 0; idx_tag = "R8";
        end else if (m_idx == last) begin
          m_idx = 0; idx_tag = "R3";
        end else begin
          m_idx = m_idx + 1;
        end
        m_pull = (m_idx == last) ? 1 : 0;
        m_pend = 0;
      end else begin
        m_pend = m_pend | changed;
        if (fell) idx_tag = "R7";
      end
      if (fell && !realign && phase_tick) idx_tag = "R7";
      void'(line_hist.pop_back());
      line_hist.push_front(int'(sync_in));
      m_prev_mode = int'(mux_mode);
      m_primed = 1;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(idx_tag,  "bp_index",  int'(bp_index),  m_idx);
      chk(pull_tag, "sync_pull", int'(sync_pull), m_pull);
      chk("R6",     "bp_active", int'(bp_active), 1 << m_idx);
      phase_tick = (tcnt % 6 == 0);
      tcnt++;
      ext_low = (ext_cnt > 0);
      if (ext_cnt > 0) ext_cnt--;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "bp_index reset",  int'(bp_index),  0);
    chk("R1", "bp_active reset", int'(bp_active), 1);
    chk("R1", "sync_pull reset", int'(sync_pull), 0);
    rst_n = 1'b1;
    run(1);
    chk("R1", "bp_index after reset", int'(bp_index), 0);

    run(250);                        // 1:4 with own sync feedback
    mux_mode = 2'd1; run(130);       // 1:2
    mux_mode = 2'd2; run(130);       // 1:3
    mux_mode = 2'd0; run(70);        // static
    mux_mode = 2'd3; run(30);

    for (int off = 0; off < 12; off++) begin
      ext_cnt = 3;
      run(20 + off);
    end
    mux_mode = 2'd2; run(30);
    for (int off = 0; off < 12; off++) begin
      ext_cnt = 2;
      run(17 + off);
    end
    mux_mode = 2'd1; run(3);
    mux_mode = 2'd3; run(40);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    finish_run();
  end
endmodule